// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block monitors a bank of 32 external input lines and records a pending flag for any line on which a chosen transition is seen. Each line selects its trigger transition with two independent enables, one for low-to-high and one for high-to-low; setting both makes it trigger on either. Inputs are first brought into the clock domain by a two-stage synchroniser, and edges are found by comparing the synchronised level with its value one clock earlier.

Software works the block through a simple register port. That port holds an interrupt mask, an event mask, the two trigger-enable registers, a software trigger register and the pending register. Pending flags are cleared by writing ones. The block drives one combined interrupt request and a one-clock event pulse. Which lines exist is set by a parameter. Bits for absent lines stay at zero, so software can find the available lines by writing all ones to a trigger-enable register and reading it back.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads 0 and both `irq_out` and `evt_out` are low. Byte offsets on `reg_addr`: 0x00 interrupt mask, 0x04 event mask, 0x08 rising enable, 0x0C falling enable, 0x10 software trigger, 0x14 pending. Bit n of each register belongs to line n.
- R2: A line with only its rising enable set latches pending on a 0-to-1 input change. The pending bit reads 1 after the third rising clock edge that follows the input change, and still reads 0 after the second.
- R3: A line with only its falling enable set latches pending on a 1-to-0 change and ignores 0-to-1.
- R4: A line with both enables set latches pending on either change.
- R5: A line with neither enable set never sets pending from its input.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: When a selected edge and a clearing write hit the same pending bit on the same clock edge, the bit stays 1.
- R8: `irq_out` is high exactly when some line has both its pending bit and its interrupt-mask bit at 1.
- R9: `evt_out` is high for exactly one clock, registered on the same edge that would latch pending, when a selected edge occurs on a line whose event-mask bit is 1. This holds whatever the pending and interrupt-mask state.
- R10: Writing 1 to a software trigger bit sets that pending bit on the write's clock edge. The trigger bit reads 1 until the pending bit is cleared, and then reads 0.
- R11: Bits of lines outside `IMPL_MASK` read 0 in every register and ignore writes. Writing all ones to the rising enable register reads back `IMPL_MASK`.
- R12: The mask, event-mask and trigger-enable registers each read back the value last written to them (within `IMPL_MASK`), including all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lines_in | input | 32 | Asynchronous external lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |
| evt_out | output | 1 | One-clock event pulse |

## Verification
On every cycle the assertions check four things. A detected selected edge always leaves its pending bit set. A clear with no competing set always drops the bit. A pending bit can only fall through a clearing write. The event pulse follows an event-enabled edge and nothing else. They also check that a trigger-enable write reads back masked to the implemented lines. What the assertions cannot show comes from the bench scenarios: the exact three-edge latency from pin to pending, the per-mode edge table, the interrupt gating by mask, the software trigger readback, and line discovery.

// File: rtl/extint_pkg.sv
// Shared definitions for the external interrupt controller: register
// offsets and the decoded register select.
package extint_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_IMASK  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_EMASK  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RISE   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_FALL   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 5'h14;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_IMASK, SEL_EMASK, SEL_RISE, SEL_FALL, SEL_SWTRIG, SEL_PEND
    } reg_sel_e;

    // Map a byte offset onto a register select.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_IMASK:  return SEL_IMASK;
            OFS_EMASK:  return SEL_EMASK;
            OFS_RISE:   return SEL_RISE;
            OFS_FALL:   return SEL_FALL;
            OFS_SWTRIG: return SEL_SWTRIG;
            OFS_PEND:   return SEL_PEND;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/extint_sync.sv
// Per-line two-flop synchroniser plus edge detector.
// Assumes: lines_in is asynchronous; only lines set in IMPL_MASK get flops,
// the others report no edges.
module extint_sync #(
    parameter int               LINES     = 32,
    parameter logic [LINES-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_in,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (IMPL_MASK[i]) begin : g_impl
            logic meta, stab, prev;
            // Resynchronise the pin and keep its previous stable level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta <= 1'b0;
                    stab <= 1'b0;
                    prev <= 1'b0;
                end else begin
                    meta <= lines_in[i];
                    stab <= meta;
                    prev <= stab;
                end
            end
            assign rise[i] = stab & ~prev;
            assign fall[i] = ~stab & prev;
        end else begin : g_absent
            assign rise[i] = 1'b0;
            assign fall[i] = 1'b0;
        end
    end
endmodule

// File: rtl/extint_regs.sv
// Configuration registers: interrupt mask, event mask, rising and falling
// enables. Assumes: writes are single-cycle strobes; bits outside IMPL_MASK
// are never stored.
module extint_regs
    import extint_pkg::*;
#(
    parameter int               LINES     = 32,
    parameter logic [LINES-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] imask,
    output logic [LINES-1:0] emask,
    output logic [LINES-1:0] rise_en,
    output logic [LINES-1:0] fall_en
);
    logic [LINES-1:0] wmasked;
    assign wmasked = wdata & IMPL_MASK;

    // Load the selected configuration register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask   <= '0;
            emask   <= '0;
            rise_en <= '0;
            fall_en <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_IMASK: imask   <= wmasked;
                SEL_EMASK: emask   <= wmasked;
                SEL_RISE:  rise_en <= wmasked;
                SEL_FALL:  fall_en <= wmasked;
                default: ;
            endcase
        end
    end

    // R11
    rise_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RISE) |=> (rise_en == ($past(wdata) & IMPL_MASK)));
    // R12
    fall_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FALL) |=> (fall_en == ($past(wdata) & IMPL_MASK)));
endmodule

// File: rtl/extint_pend.sv
// Pending latch, software trigger register and event pulse.
// Assumes: rise/fall are single-cycle edge flags; clr and sw_set carry
// write data already qualified by the write strobe and the line mask.
module extint_pend #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rise,
    input  logic [LINES-1:0] fall,
    input  logic [LINES-1:0] rise_en,
    input  logic [LINES-1:0] fall_en,
    input  logic [LINES-1:0] emask,
    input  logic [LINES-1:0] clr,
    input  logic [LINES-1:0] sw_set,
    output logic [LINES-1:0] pend,
    output logic [LINES-1:0] swtrig,
    output logic             evt
);
    logic [LINES-1:0] hit;
    logic [LINES-1:0] pend_nx;

    assign hit     = (rise & rise_en) | (fall & fall_en);
    // Sets take priority over a same-cycle clear.
    assign pend_nx = (pend & ~clr) | hit | sw_set;

    // Update pending flags, software trigger bits and the event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            swtrig <= '0;
            evt    <= 1'b0;
        end else begin
            pend   <= pend_nx;
            swtrig <= (swtrig | sw_set) & pend_nx;
            evt    <= |(hit & emask);
        end
    end

    // R7
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((pend & $past(hit)) == $past(hit)));
    // R6
    clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~hit & ~sw_set)) |=> ((pend & $past(clr & ~hit & ~sw_set)) == '0));
    // R6
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));
    // R9
    evt_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & emask)) |=> evt);
    // R9
    evt_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(hit & emask)) |=> !evt);
endmodule

// File: rtl/extint_ctrl.sv
// Top of the edge-triggered external interrupt controller: register port
// decode, read mux and combined interrupt request.
// Assumes: one register access per cycle; reads are combinational.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int               LINES     = 32,
    parameter logic [LINES-1:0] IMPL_MASK = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  lines_in,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    output logic              irq_out,
    output logic              evt_out
);
    reg_sel_e         sel;
    logic [LINES-1:0] rise, fall;
    logic [LINES-1:0] imask, emask, rise_en, fall_en;
    logic [LINES-1:0] pend, swtrig;
    logic [LINES-1:0] clr, sw_set;

    assign sel    = decode_addr(reg_addr);
    assign clr    = (reg_wr_en && sel == SEL_PEND)   ? (reg_wdata & IMPL_MASK) : '0;
    assign sw_set = (reg_wr_en && sel == SEL_SWTRIG) ? (reg_wdata & IMPL_MASK) : '0;

    extint_sync #(.LINES(LINES), .IMPL_MASK(IMPL_MASK)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .rise(rise), .fall(fall)
    );

    extint_regs #(.LINES(LINES), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(sel), .wdata(reg_wdata),
        .imask(imask), .emask(emask), .rise_en(rise_en), .fall_en(fall_en)
    );

    extint_pend #(.LINES(LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .rise_en(rise_en), .fall_en(fall_en), .emask(emask),
        .clr(clr), .sw_set(sw_set), .pend(pend), .swtrig(swtrig), .evt(evt_out)
    );

    // Select read data for the addressed register.
    always_comb begin
        case (sel)
            SEL_IMASK:  reg_rdata = imask;
            SEL_EMASK:  reg_rdata = emask;
            SEL_RISE:   reg_rdata = rise_en;
            SEL_FALL:   reg_rdata = fall_en;
            SEL_SWTRIG: reg_rdata = swtrig;
            SEL_PEND:   reg_rdata = pend;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_out = |(pend & imask);

    // R11
    absent_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend | swtrig | imask | emask) & ~IMPL_MASK) == '0);
    // R10
    swtrig_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_set) |=> ((pend & $past(sw_set)) == $past(sw_set)));
endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
    import extint_pkg::*;

    localparam logic [31:0] IMPL = 32'h00FF_FFFF;
    // {rise_en, fall_en, start level, end level, expected pending}
    localparam logic [4:0] VEC [0:7] = '{
        5'b10011, 5'b10100, 5'b01101, 5'b01010,
        5'b11011, 5'b11101, 5'b00010, 5'b00100
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines_in = '0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, evt_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    extint_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .evt_out(evt_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        clocks(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(5'(a * 4), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset irq_out", {31'h0, irq_out}, 32'h0);
        check("R1 reset evt_out", {31'h0, evt_out}, 32'h0);

        // Edge-mode vectors on line 0 (R2/R3/R4/R5)
        wr(OFS_IMASK, 32'h1);
        for (int k = 0; k < 8; k++) begin
            wr(OFS_RISE, {31'h0, VEC[k][4]});
            wr(OFS_FALL, {31'h0, VEC[k][3]});
            lines_in[0] = VEC[k][2];
            clocks(4);
            wr(OFS_PEND, 32'hFFFF_FFFF);
            lines_in[0] = VEC[k][1];
            clocks(4);
            rd(OFS_PEND, v);
            check($sformatf("R2/R3/R4/R5 vector %0d pending", k), v, {31'h0, VEC[k][0]});
            check($sformatf("R8 vector %0d irq", k), {31'h0, irq_out}, {31'h0, VEC[k][0]});
        end

        // R2 exact latency and R9 pulse shape, line 2 rising, events enabled
        wr(OFS_PEND, 32'hFFFF_FFFF);
        wr(OFS_IMASK, 32'h0);
        wr(OFS_RISE, 32'h4);
        wr(OFS_FALL, 32'h0);
        wr(OFS_EMASK, 32'h4);
        lines_in[2] = 1'b1;
        clocks(2);
        rd(OFS_PEND, v);
        check("R2 not yet pending after two edges", v, 32'h0);
        clocks(1);
        rd(OFS_PEND, v);
        check("R2 pending after three edges", v, 32'h4);
        check("R9 event pulse high", {31'h0, evt_out}, 32'h1);
        check("R8 irq low with mask clear", {31'h0, irq_out}, 32'h0);
        clocks(1);
        check("R9 event pulse one clock", {31'h0, evt_out}, 32'h0);
        wr(OFS_IMASK, 32'h4);
        check("R8 irq high once unmasked", {31'h0, irq_out}, 32'h1);

        // R6 write-zero keeps, write-one clears
        wr(OFS_PEND, 32'h0);
        rd(OFS_PEND, v);
        check("R6 write zero keeps pending", v, 32'h4);
        wr(OFS_PEND, 32'h4);
        rd(OFS_PEND, v);
        check("R6 write one clears pending", v, 32'h0);

        // R7 edge beats same-cycle clear: falling edge on line 2 with both enabled
        wr(OFS_FALL, 32'h4);
        wr(OFS_SWTRIG, 32'h4);
        wr(OFS_SWTRIG, 32'h0);
        lines_in[2] = 1'b0;           // change before edge E1
        @(negedge clk);               // after E1
        @(negedge clk);               // after E2
        reg_wr_en = 1'b1; reg_addr = OFS_PEND; reg_wdata = 32'h4;
        @(negedge clk);               // after E3: hit and clear together
        reg_wr_en = 1'b0;
        rd(OFS_PEND, v);
        check("R7 edge wins over clear", v, 32'h4);
        check("R9 event with pending already set", {31'h0, evt_out}, 32'h1);

        // R10 software trigger
        wr(OFS_PEND, 32'hFFFF_FFFF);
        wr(OFS_SWTRIG, 32'h8);
        rd(OFS_PEND, v);
        check("R10 software trigger sets pending", v, 32'h8);
        rd(OFS_SWTRIG, v);
        check("R10 software bit reads one", v, 32'h8);
        wr(OFS_PEND, 32'h8);
        rd(OFS_SWTRIG, v);
        check("R10 software bit drops after clear", v, 32'h0);

        // R11 line discovery and absent lines
        wr(OFS_RISE, 32'hFFFF_FFFF);
        rd(OFS_RISE, v);
        check("R11 discovery mask", v, IMPL);
        wr(OFS_SWTRIG, 32'h8000_0000);
        rd(OFS_PEND, v);
        check("R11 absent line not pending", v, 32'h0);
        lines_in[31] = 1'b1;
        clocks(4);
        rd(OFS_PEND, v);
        check("R11 absent pin ignored", v, 32'h0);
        wr(OFS_EMASK, 32'hFFFF_FFFF);
        rd(OFS_EMASK, v);
        check("R11 event mask limited", v, IMPL);

        // R12 configuration back to zero
        wr(OFS_IMASK, 32'h0);
        wr(OFS_EMASK, 32'h0);
        wr(OFS_RISE, 32'h0);
        wr(OFS_FALL, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rd(5'(a * 4), v);
            check("R12 config cleared", v, 32'h0);
        end
        wr(OFS_FALL, 32'h0012_3456);
        rd(OFS_FALL, v);
        check("R12 falling readback", v, 32'h0012_3456);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule